// File: doc/BRIEF.md
# Magic-Sequence Watchdog with Reset Cause

This block is a watchdog timer on a simple 32-bit register bus. Once enabled, it counts clock cycles up to a power-of-two limit set by a 5-bit delay field. If software does not service it in time, it raises a system reset request. Servicing takes two fixed magic words, written in order to two service registers. Any other pattern aimed at those registers is treated as a fault and also raises the reset request, with its own cause code.

Clearing the enable bit does not stop the count at once. The count stops at the next correct service, so a runaway program cannot switch the watchdog off with a single stray write. A write to the soft-reset register raises the request directly. A three-bit cause latch records why the last reset happened and keeps that value across every reset except the power-on reset. The reset request is a fixed-length pulse. When the request starts, the rest of the block's state returns to idle.

Top module: `wdog_magic`

## Requirements
- R1: After power-on reset, `rst_req` is low and every register reads zero. A read of byte offset 0x4 returns the stored enable in bit 31 and the stored delay in bits [4:0]. A read of 0x8 returns the cause code in bits [2:0]. Reads of 0x0 and 0xC return zero.
- R2: A write to 0x4 with bit 31 set, made while the block is stopped, starts the count from zero. `rst_req` rises exactly 2^(delay+1) cycles after that write's clock edge. While the block is stopped, the count is held at zero.
- R3: A valid service is 0xABCD1234 written to 0x8, followed by 0x4321DCBA written to 0xC as the very next bus write. It restarts the count, so `rst_req` rises 2^(delay+1) cycles after the second write. A valid service that lands on the same edge as the expiry still wins.
- R4: A write to 0x4 with bit 31 clear does not stop a running count. The stop takes effect at the next valid service.
- R5: While running, the following raise `rst_req` on the write's edge with cause 2:
  - a wrong word written to 0x8;
  - a write to 0xC with the wrong word;
  - a write to 0xC not directly preceded by a correct 0x8 write, including when another register write comes between the two.
  While stopped, none of these has any effect.
- R6: Writing 0x0 with bit 0 set raises `rst_req` with cause 3, whether or not the block is enabled. Writing 0x0 with bit 0 clear does nothing.
- R7: The request lasts exactly 16 cycles. The edge that starts it clears the enable, the delay and the count. Bus writes during the pulse are ignored.
- R8: The cause codes are 1 for timeout, 2 for a bad service, 3 for soft reset and 4 for user reset. Only the power-on reset sets the cause to 0. The `usr_rst` input sets the cause to 4, clears the configuration and raises no request. The cause survives the block's own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| usr_rst | input | 1 | Synchronous external user reset, active high |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | System reset request pulse |

## Verification
Most internal faults show up on `rst_req`.
- A count that is wrong or fails to restart moves the rising edge of `rst_req` away from the exact cycle the delay dictates. The bench checks `rst_req` on every cycle against that cycle, so the fault is reported on the first edge that differs.
- A faulty service checker or deferred-disable path either raises a request where none is due, or stays silent through a window several times the period.
- A faulty cause latch is seen through the read of 0x8, right after each pulse ends.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   typedef enum logic [2:0] {
      CAUSE_POWER   = 3'd0,
      CAUSE_EXPIRED = 3'd1,
      CAUSE_BADSVC  = 3'd2,
      CAUSE_SOFT    = 3'd3,
      CAUSE_USER    = 3'd4
   } cause_e;

   localparam logic [3:0] OFS_SOFT  = 4'h0;
   localparam logic [3:0] OFS_CFG   = 4'h4;
   localparam logic [3:0] OFS_SVC_A = 4'h8;
   localparam logic [3:0] OFS_SVC_B = 4'hC;

   localparam logic [31:0] KEY_A = 32'hABCD_1234;
   localparam logic [31:0] KEY_B = 32'h4321_DCBA;
endpackage

// File: rtl/wdog_svc_chk.sv
`timescale 1ns/1ps
module wdog_svc_chk
   import wdog_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic              wr_other,
   input  logic [DATA_W-1:0] wdata,
   output logic              svc_ok,
   output logic              svc_bad
);
   logic armed_q;
   logic key_a_hit, key_b_hit;

   assign key_a_hit = (wdata == KEY_A);
   assign key_b_hit = (wdata == KEY_B);

   assign svc_ok  = wr_b && armed_q && key_b_hit;
   assign svc_bad = (wr_a && !key_a_hit) || (wr_b && !(armed_q && key_b_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed_q <= 1'b0;
      else if (clr)              armed_q <= 1'b0;
      else if (wr_a)             armed_q <= key_a_hit;
      else if (wr_b || wr_other) armed_q <= 1'b0;
   end
endmodule

// File: rtl/wdog_tick_cnt.sv
`timescale 1ns/1ps
module wdog_tick_cnt #(
   parameter int DLY_W = 5,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [DLY_W-1:0] dly,
   output logic             expire,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [DLY_W:0]   shamt;
   logic [CNT_W-1:0] limit;

   // limit = 2^(dly+1) - 1, formed by shifting ones out of an all-ones word
   assign shamt  = {1'b0, dly} + {{DLY_W{1'b0}}, 1'b1};
   assign limit  = ~({CNT_W{1'b1}} << shamt);
   assign expire = run && (cnt_q == limit);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || clear)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/wdog_rst_pulse.sv
`timescale 1ns/1ps
module wdog_rst_pulse #(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clr,
   output logic busy
);
   generate
      if (PULSE_LEN == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= fire && !clr;
         end
         assign busy = busy_q;
      end else begin : g_count
         localparam int LW = $clog2(PULSE_LEN + 1);
         logic [LW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (clr)            left_q <= '0;
            else if (fire)           left_q <= LW'(PULSE_LEN);
            else if (left_q != '0)   left_q <= left_q - LW'(1);
         end
         assign busy = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_magic.sv
`timescale 1ns/1ps
module wdog_magic
   import wdog_pkg::*;
#(
   parameter int DLY_W     = 5,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_rst,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req
);
   localparam int CNT_W  = 1 << DLY_W;
   localparam int EN_BIT = DATA_W - 1;

   generate
      if (DLY_W < 1 || DLY_W > 5) begin : g_bad_dly
         $error("wdog_magic: DLY_W must lie in 1..5");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("wdog_magic: DATA_W must be 32 to hold the service keys");
      end
      if (ADDR_W != 4) begin : g_bad_addr
         $error("wdog_magic: ADDR_W must be 4");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("wdog_magic: PULSE_LEN must be at least 1");
      end
   endgenerate

   logic             cfg_en_q;
   logic [DLY_W-1:0] cfg_dly_q;
   logic             run_q;
   logic [2:0]       cause_q;
   logic             busy;
   logic             wr_ok, wr_soft, wr_cfg, wr_a, wr_b, wr_other;
   logic             svc_ok, svc_bad, expire;
   logic             fire_soft, fire_bad, fire_tmo, fire, clr;
   logic [CNT_W-1:0] cnt_w;
   cause_e           fire_code;

   // ---------------- bus decode ----------------
   assign wr_ok    = bus_wr && !busy && !usr_rst;
   assign wr_soft  = wr_ok && (bus_addr == OFS_SOFT);
   assign wr_cfg   = wr_ok && (bus_addr == OFS_CFG);
   assign wr_a     = wr_ok && (bus_addr == OFS_SVC_A);
   assign wr_b     = wr_ok && (bus_addr == OFS_SVC_B);
   assign wr_other = wr_ok && !wr_a && !wr_b;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_CFG)
         bus_rdata = {cfg_en_q, {(DATA_W-1-DLY_W){1'b0}}, cfg_dly_q};
      else if (bus_addr == OFS_SVC_A)
         bus_rdata = {{(DATA_W-3){1'b0}}, cause_q};
   end

   // ---------------- sub-blocks ----------------
   wdog_svc_chk #(.DATA_W(DATA_W)) u_svc (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_a(wr_a), .wr_b(wr_b), .wr_other(wr_other),
      .wdata(bus_wdata), .svc_ok(svc_ok), .svc_bad(svc_bad)
   );

   wdog_tick_cnt #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .clear(clr || svc_ok),
      .dly(cfg_dly_q), .expire(expire), .cnt_o(cnt_w)
   );

   wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .clr(usr_rst), .busy(busy)
   );

   // ---------------- fire arbitration ----------------
   assign fire_soft = wr_soft && bus_wdata[0];
   assign fire_bad  = svc_bad && run_q;
   assign fire_tmo  = expire && !svc_ok;
   assign fire      = fire_soft || fire_bad || fire_tmo;
   assign clr       = fire || usr_rst;

   always_comb begin
      if (fire_soft)     fire_code = CAUSE_SOFT;
      else if (fire_bad) fire_code = CAUSE_BADSVC;
      else               fire_code = CAUSE_EXPIRED;
   end

   // ---------------- configuration and run state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q  <= 1'b0;
         cfg_dly_q <= '0;
         run_q     <= 1'b0;
      end else if (clr) begin
         cfg_en_q  <= 1'b0;
         cfg_dly_q <= '0;
         run_q     <= 1'b0;
      end else begin
         if (wr_cfg) begin
            cfg_en_q  <= bus_wdata[EN_BIT];
            cfg_dly_q <= bus_wdata[DLY_W-1:0];
         end
         if (wr_cfg && bus_wdata[EN_BIT]) run_q <= 1'b1;
         else if (svc_ok)                 run_q <= cfg_en_q;
      end
   end

   // ---------------- cause latch: cleared by power-on reset only ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cause_q <= CAUSE_POWER;
      else if (usr_rst) cause_q <= CAUSE_USER;
      else if (fire)    cause_q <= fire_code;
   end

   assign rst_req = busy;
endmodule

// File: rtl/wdog_magic_chk.sv
`timescale 1ns/1ps
module wdog_magic_chk #(
   parameter int CNT_W     = 32,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int PULSE_LEN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              usr_rst,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rst_req,
   input logic              run_q,
   input logic              cfg_en_q,
   input logic [2:0]        cause_q,
   input logic [CNT_W-1:0]  cnt_w
);
   localparam int HW = $clog2(PULSE_LEN + 2);
   logic [HW-1:0] hi_len;
   logic          live_wr;

   assign live_wr = bus_wr && !rst_req && !usr_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (rst_req) hi_len <= hi_len + HW'(1);
      else              hi_len <= '0;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (cnt_w == '0));

   assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_wr && run_q && bus_addr == ADDR_W'(8) && bus_wdata != DATA_W'(32'hABCD_1234))
      |=> (rst_req && cause_q == 3'd2));

   assert_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_wr && bus_addr == ADDR_W'(0) && bus_wdata[0])
      |=> (rst_req && cause_q == 3'd3));

   assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_req) && !$past(usr_rst)) |-> (hi_len == HW'(PULSE_LEN)));

   assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> (!cfg_en_q && !run_q));

   assert_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rst |=> (!rst_req && cause_q == 3'd4 && !cfg_en_q));
endmodule

bind wdog_magic wdog_magic_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .usr_rst(usr_rst), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_req(rst_req),
   .run_q(run_q), .cfg_en_q(cfg_en_q), .cause_q(cause_q), .cnt_w(cnt_w)
);

// File: tb/sim_wdog_magic.sv
`timescale 1ns/1ps
module sim_wdog_magic;
   localparam int NEVER = 1000000;
   localparam int PLEN  = 16;
   localparam logic [31:0] KA = 32'hABCD_1234;
   localparam logic [31:0] KB = 32'h4321_DCBA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        usr_rst = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int    nvec = 0;
   int    nfail = 0;
   bit    mon_on = 1'b0;
   int    mon_e = 0;
   int    fire_at = NEVER;
   string mon_tag = "";

   always #2.5 clk = ~clk;

   wdog_magic u0 (
      .clk(clk), .rst_n(rst_n), .usr_rst(usr_rst), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req)
   );

   function automatic logic exp_req(input int e, input int fa);
      return (e >= fa) && (e < fa + PLEN);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (mon_on) begin
         mon_e++;
         check(mon_tag, {31'b0, rst_req}, {31'b0, exp_req(mon_e, fire_at)});
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      bus_addr = '0;
   endtask

   task automatic mon_start(input string tag, input int fa);
      mon_on = 1'b1; mon_e = 0; fire_at = fa; mon_tag = tag;
   endtask

   task automatic mon_stop();
      mon_on = 1'b0;
   endtask

   task automatic hard_rst();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      #(5.0 * 200000);
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state and read map
      check("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
      rd("R1 cfg after reset", 4'h4, 32'h0);
      rd("R1 cause after reset", 4'h8, 32'h0);
      rd("R1 soft reads zero", 4'h0, 32'h0);
      rd("R1 svc B reads zero", 4'hC, 32'h0);

      // R2 timeout with delay 2 -> 8 cycles
      wr(4'h4, 32'h8000_0002);
      mon_start("R2 timeout edge", 8);
      rd("R1 cfg readback", 4'h4, 32'h8000_0002);
      idle(8 + PLEN + 2);
      mon_stop();
      rd("R8 cause timeout", 4'h8, 32'h1);
      rd("R7 cfg cleared by request", 4'h4, 32'h0);

      // R7 writes during pulse ignored
      wr(4'h4, 32'h8000_0001);
      mon_start("R7 pulse length", 4);
      idle(5);
      wr(4'h4, 32'h8000_0003);
      idle(PLEN);
      mon_stop();
      rd("R7 write in pulse ignored", 4'h4, 32'h0);

      // R3 service restarts the count
      wr(4'h4, 32'h8000_0003);
      mon_start("R3 restart", 10 + 16);
      idle(8);
      wr(4'h8, KA);
      wr(4'hC, KB);
      idle(33);
      mon_stop();
      rd("R8 cause after restart expiry", 4'h8, 32'h1);

      // R3 service on the expiry edge wins
      wr(4'h4, 32'h8000_0002);
      mon_start("R3 service on expiry edge", 16);
      idle(6);
      wr(4'h8, KA);
      wr(4'hC, KB);
      idle(26);
      mon_stop();

      // R4 clearing enable alone keeps counting
      wr(4'h4, 32'h8000_0001);
      mon_start("R4 disable deferred", 4);
      wr(4'h4, 32'h0000_0001);
      rd("R4 stored enable clear", 4'h4, 32'h0000_0001);
      idle(PLEN + 6);
      mon_stop();

      // R4 stop takes effect at valid service
      wr(4'h4, 32'h8000_0002);
      mon_start("R4 stopped after service", NEVER);
      wr(4'h4, 32'h0000_0002);
      wr(4'h8, KA);
      wr(4'hC, KB);
      idle(40);
      mon_stop();

      // R5 bad sequences ignored while stopped
      mon_start("R5 ignored while stopped", NEVER);
      wr(4'hC, KB);
      wr(4'h8, 32'hDEAD_BEEF);
      idle(5);
      mon_stop();
      rd("R5 cause unchanged while stopped", 4'h8, 32'h1);

      // R5 wrong key to 0x8
      wr(4'h4, 32'h8000_0004);
      mon_start("R5 wrong key A", 1);
      wr(4'h8, 32'h1234_5678);
      idle(PLEN + 4);
      mon_stop();
      rd("R5 cause bad service", 4'h8, 32'h2);

      // R6 soft reset
      mon_start("R6 soft reset", 5);
      wr(4'h0, 32'h0000_0002);
      idle(3);
      rd("R6 bit0 clear no effect", 4'h8, 32'h2);
      wr(4'h0, 32'h0000_0001);
      idle(PLEN + 2);
      mon_stop();
      rd("R6 cause soft", 4'h8, 32'h3);

      // R5 0xC without preceding 0x8
      wr(4'h4, 32'h8000_0004);
      mon_start("R5 unarmed key B", 1);
      wr(4'hC, KB);
      idle(PLEN + 4);
      mon_stop();
      rd("R5 cause unarmed", 4'h8, 32'h2);

      // R8 user reset
      wr(4'h4, 32'h8000_0001);
      mon_start("R8 user reset no request", NEVER);
      usr_rst = 1'b1;
      cyc();
      usr_rst = 1'b0;
      idle(20);
      mon_stop();
      rd("R8 cause user", 4'h8, 32'h4);
      rd("R8 cfg cleared by user", 4'h4, 32'h0);

      // R5 intervening write breaks the pair
      wr(4'h4, 32'h8000_0004);
      mon_start("R5 intervening write", 3);
      wr(4'h8, KA);
      wr(4'h4, 32'h8000_0004);
      wr(4'hC, KB);
      idle(PLEN + 4);
      mon_stop();
      rd("R5 cause intervening", 4'h8, 32'h2);

      // R8 power-on reset clears cause
      hard_rst();
      rd("R8 cause after power-on", 4'h8, 32'h0);
      rd("R1 cfg after power-on", 4'h4, 32'h0);

      // R5 wrong key to 0xC after correct 0x8
      wr(4'h4, 32'h8000_0004);
      mon_start("R5 wrong key B", 2);
      wr(4'h8, KA);
      wr(4'hC, 32'h0);
      idle(PLEN + 4);
      mon_stop();
      rd("R5 cause wrong B", 4'h8, 32'h2);

      // R3 / R2 random service timing
      for (int it = 0; it < 40; it++) begin
         int d, p, k, t, fa;
         d  = $urandom_range(0, 4);
         p  = 1 << (d + 1);
         k  = $urandom_range(0, p + 2);
         t  = k + 2;
         fa = (t <= p) ? t + p : p;
         wr(4'h4, 32'h8000_0000 | d);
         mon_start("R3 random service timing", fa);
         idle(k);
         wr(4'h8, KA);
         wr(4'hC, KB);
         while (mon_e < fa + PLEN + 2) cyc();
         mon_stop();
         rd("R8 cause after random run", 4'h8, 32'h1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule